// File: doc/BRIEF.md
# Hexadecimal Floating-Point Post-Normalizer

This block takes the raw fraction from a base-16 floating-point add or subtract and brings it into normal form. The fraction is moved left by whole hex digits (4 bits each) until its top digit is nonzero. The 7-bit excess-64 exponent is lowered by one for every digit moved. Both a 24-bit short fraction and a 56-bit long fraction are handled, and each request selects its own format. Control inputs sent with each request choose unnormalized handling (no shift), significance checking, how an exponent underflow is handled, and whether an all-zero fraction becomes a true zero.

A request is a single-cycle `start` pulse with all operands valid. The whole shift is done at once by a digit-granular barrel shifter. The result registers load on that same clock edge, and `done` is high for exactly the following cycle. The results stay on the outputs until the next request. A 4-bit condition code gives the underflow and significance indications and the sign class of the result. A trap sequencer outside this block uses these flags.

Top module: `hexfp_normalizer`

## Requirements
- R1: After reset `done`, `sign_out`, `exp_out`, `frac_out`, `sig_fault`, `uflow_fault` and `cc` are all zero.
- R2: `done` is high in exactly the one cycle after a cycle with `start` high. All result outputs change only on a `start` edge and hold their values otherwise.
- R3: The short format uses only `frac_in[55:32]`; `frac_in[31:0]` is ignored, and `frac_out[31:0]` is zero for a short result. When `unnorm_mode` is 0 and the fraction is nonzero, the fraction is shifted left by the number of leading zero hex digits. The exponent drops by that count, and the result's top digit `frac_out[55:52]` is nonzero.
- R4: When `unnorm_mode` is 1 there is no shift: the exponent, sign and format-masked fraction pass unchanged, and no fault is raised.
- R5: `sig_fault` is 1 exactly when `sig_chk_en` is 1, `unnorm_mode` is 0, the fraction is nonzero and the shift exceeds two hex digits. This applies even when the result is then forced to zero.
- R6: An underflow occurs when the shift count exceeds `exp_in`. With `uflow_zero` at 0, `uflow_fault` is 1, the fraction is normalized and `exp_out` is `(exp_in - shift) mod 128`.
- R7: With `uflow_zero` at 1, an underflow gives a true zero (sign, exponent and fraction all 0) and `uflow_fault` stays 0.
- R8: An all-zero fraction is never shifted and never raises `sig_fault`. With `zero_chk_en` at 1 the result is a true zero. With `zero_chk_en` at 0 the fraction is zero while the sign and exponent pass unchanged.
- R9: `cc[3]` is 1 when an underflow is detected (either handling) and `cc[2]` equals `sig_fault`. `cc[1]` is 1 for a nonzero result with `sign_out` = 1, and `cc[0]` is 1 for a nonzero result with `sign_out` = 0. A zero result gives `cc[1:0]` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe; operands valid with it |
| long_fmt | input | 1 | 1 = 56-bit fraction, 0 = 24-bit fraction in bits 55:32 |
| unnorm_mode | input | 1 | 1 = skip normalizing shift |
| sig_chk_en | input | 1 | Enable significance fault on shifts above two digits |
| uflow_zero | input | 1 | 1 = underflow yields true zero, 0 = underflow fault |
| zero_chk_en | input | 1 | 1 = zero fraction yields true zero |
| sign_in | input | 1 | Sign of the raw result |
| exp_in | input | 7 | Excess-64 exponent of the raw result |
| frac_in | input | 56 | Raw fraction, top-aligned |
| done | output | 1 | High for the cycle after `start` |
| sign_out | output | 1 | Result sign |
| exp_out | output | 7 | Result exponent |
| frac_out | output | 56 | Result fraction |
| sig_fault | output | 1 | Significance fault |
| uflow_fault | output | 1 | Exponent underflow fault |
| cc | output | 4 | Condition code {underflow, significance, minus, plus} |

## Verification
Every result of a request, including `done`, the fault flags and the condition code, appears one clock edge after the edge that samples `start`. The bench sets up its stimulus on a falling edge and reads all outputs at the next falling edge, half a period after the loading edge. One further falling edge later it checks that `done` has dropped and that the held results have not moved, even though the inputs were changed without a strobe. Expected values come from a bench model that shifts one digit at a time in a loop, not from a leading-digit count.

// File: rtl/hexfp_pkg.sv
package hexfp_pkg;
  localparam int HFP_EXP_W   = 7;
  localparam int HFP_FRAC_W  = 56;
  localparam int HFP_SHORT_W = 24;
  localparam int HFP_DIG_W   = 4;
  localparam int HFP_CC_W    = 4;
  localparam int HFP_DIGITS  = HFP_FRAC_W / HFP_DIG_W;
  localparam int HFP_CNT_W   = $clog2(HFP_DIGITS + 1);

  // condition code bit positions
  localparam int CC_UFLOW = 3;
  localparam int CC_SIG   = 2;
  localparam int CC_MINUS = 1;
  localparam int CC_PLUS  = 0;
endpackage

// File: rtl/hexfp_digit_scan.sv
module hexfp_digit_scan #(
  parameter int FRAC_W  = 56,
  parameter int SHORT_W = 24,
  parameter int DIG_W   = 4,
  parameter int CNT_W   = 4
) (
  input  logic [FRAC_W-1:0] frac,
  input  logic              long_fmt,
  output logic [CNT_W-1:0]  lead_zeros,
  output logic              all_zero
);
  localparam int NDIG_L = FRAC_W / DIG_W;
  localparam int NDIG_S = SHORT_W / DIG_W;

  function automatic logic [CNT_W-1:0] count_lead(input logic [FRAC_W-1:0] f,
                                                  input logic lf);
    logic [CNT_W-1:0] n;
    logic             hit;
    int               lim;
    n   = '0;
    hit = 1'b0;
    lim = lf ? NDIG_L : NDIG_S;
    for (int i = 0; i < NDIG_L; i++) begin
      if (!hit && i < lim) begin
        if (f[FRAC_W-1-DIG_W*i -: DIG_W] != '0) hit = 1'b1;
        else n = n + 1'b1;
      end
    end
    return n;
  endfunction

  assign lead_zeros = count_lead(frac, long_fmt);
  assign all_zero   = (frac == '0);
endmodule

// File: rtl/hexfp_digit_shift.sv
module hexfp_digit_shift #(
  parameter int FRAC_W = 56,
  parameter int DIG_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic [FRAC_W-1:0] din,
  input  logic [CNT_W-1:0]  amt,
  output logic [FRAC_W-1:0] dout
);
  logic [FRAC_W-1:0] stage [0:CNT_W];

  assign stage[0] = din;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int STEP = DIG_W * (2 ** s);
    if (STEP < FRAC_W) begin : g_sh
      assign stage[s+1] = amt[s] ? (stage[s] << STEP) : stage[s];
    end else begin : g_clr
      assign stage[s+1] = amt[s] ? '0 : stage[s];
    end
  end

  assign dout = stage[CNT_W];
endmodule

// File: rtl/hexfp_cc_encode.sv
module hexfp_cc_encode #(
  parameter int CC_W = 4
) (
  input  logic            uflow_seen,
  input  logic            sig_seen,
  input  logic            sign,
  input  logic            nonzero,
  output logic [CC_W-1:0] cc
);
  import hexfp_pkg::*;

  always_comb begin
    cc           = '0;
    cc[CC_UFLOW] = uflow_seen;
    cc[CC_SIG]   = sig_seen;
    cc[CC_MINUS] = nonzero & sign;
    cc[CC_PLUS]  = nonzero & ~sign;
  end
endmodule

// File: rtl/hexfp_normalizer.sv
module hexfp_normalizer
  import hexfp_pkg::*;
#(
  parameter int EXP_W   = HFP_EXP_W,
  parameter int FRAC_W  = HFP_FRAC_W,
  parameter int SHORT_W = HFP_SHORT_W,
  parameter int DIG_W   = HFP_DIG_W,
  parameter int CC_W    = HFP_CC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_fmt,
  input  logic              unnorm_mode,
  input  logic              sig_chk_en,
  input  logic              uflow_zero,
  input  logic              zero_chk_en,
  input  logic              sign_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              done,
  output logic              sign_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic [FRAC_W-1:0] frac_out,
  output logic              sig_fault,
  output logic              uflow_fault,
  output logic [CC_W-1:0]   cc
);
  localparam int NDIG  = FRAC_W / DIG_W;
  localparam int CNT_W = $clog2(NDIG + 1);
  localparam logic [FRAC_W-1:0] SHORT_MASK = {{SHORT_W{1'b1}}, {(FRAC_W-SHORT_W){1'b0}}};
  localparam logic [CNT_W-1:0]  SIG_LIMIT  = CNT_W'(2);

  // named internal events
  logic [FRAC_W-1:0] frac_fmt;
  logic [CNT_W-1:0]  lead_zeros;
  logic              all_zero;
  logic [CNT_W-1:0]  shift_amt;
  logic [FRAC_W-1:0] frac_shifted;
  logic              uflow_hit;
  logic              sig_hit;
  logic              force_zero;
  logic [EXP_W-1:0]  exp_adj;
  logic              nx_sign;
  logic [EXP_W-1:0]  nx_exp;
  logic [FRAC_W-1:0] nx_frac;
  logic [CC_W-1:0]   nx_cc;

  assign frac_fmt = long_fmt ? frac_in : (frac_in & SHORT_MASK);

  hexfp_digit_scan #(
    .FRAC_W(FRAC_W), .SHORT_W(SHORT_W), .DIG_W(DIG_W), .CNT_W(CNT_W)
  ) u_scan (
    .frac(frac_fmt), .long_fmt(long_fmt),
    .lead_zeros(lead_zeros), .all_zero(all_zero)
  );

  assign shift_amt = (unnorm_mode || all_zero) ? '0 : lead_zeros;

  hexfp_digit_shift #(
    .FRAC_W(FRAC_W), .DIG_W(DIG_W), .CNT_W(CNT_W)
  ) u_shift (
    .din(frac_fmt), .amt(shift_amt), .dout(frac_shifted)
  );

  assign uflow_hit  = (EXP_W'(shift_amt) > exp_in);
  assign sig_hit    = sig_chk_en && (shift_amt > SIG_LIMIT);
  assign exp_adj    = exp_in - EXP_W'(shift_amt);
  assign force_zero = (all_zero && zero_chk_en) || (uflow_hit && uflow_zero);

  assign nx_sign = force_zero ? 1'b0 : sign_in;
  assign nx_exp  = force_zero ? '0   : exp_adj;
  assign nx_frac = force_zero ? '0   : frac_shifted;

  hexfp_cc_encode #(.CC_W(CC_W)) u_cc (
    .uflow_seen(uflow_hit), .sig_seen(sig_hit),
    .sign(nx_sign), .nonzero(nx_frac != '0), .cc(nx_cc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      sign_out    <= 1'b0;
      exp_out     <= '0;
      frac_out    <= '0;
      sig_fault   <= 1'b0;
      uflow_fault <= 1'b0;
      cc          <= '0;
    end else begin
      done <= start;
      if (start) begin
        sign_out    <= nx_sign;
        exp_out     <= nx_exp;
        frac_out    <= nx_frac;
        sig_fault   <= sig_hit;
        uflow_fault <= uflow_hit && !uflow_zero;
        cc          <= nx_cc;
      end
    end
  end
endmodule

// File: rtl/hexfp_normalizer_chk.sv
module hexfp_normalizer_chk #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 56,
  parameter int DIG_W  = 4,
  parameter int CC_W   = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              long_fmt,
  input logic              unnorm_mode,
  input logic              uflow_zero,
  input logic [EXP_W-1:0]  exp_in,
  input logic [FRAC_W-1:0] frac_in,
  input logic              done,
  input logic [EXP_W-1:0]  exp_out,
  input logic [FRAC_W-1:0] frac_out,
  input logic              sig_fault,
  input logic              uflow_fault,
  input logic [CC_W-1:0]   cc,
  input logic [CNT_W-1:0]  shift_amt,
  input logic              uflow_hit
);
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2
  AST_DONE_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(frac_out) && $stable(exp_out) && $stable(cc)); // R2
  AST_LEAD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !unnorm_mode |=> (frac_out == '0) || (frac_out[FRAC_W-1 -: DIG_W] != '0)); // R3
  AST_SHORT_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !long_fmt |-> shift_amt <= CNT_W'(5)); // R3
  AST_UNNORM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    start && unnorm_mode && frac_in[FRAC_W-1 -: DIG_W] != '0 |=>
      exp_out == $past(exp_in) && frac_out[FRAC_W-1 -: DIG_W] == $past(frac_in[FRAC_W-1 -: DIG_W])); // R4
  AST_ZERO_NO_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    start && frac_in == '0 |=> !sig_fault); // R8
  AST_UFLOW_ZERO_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    start && uflow_zero |=> !uflow_fault); // R7
  AST_UFLOW_CC: assert property (@(posedge clk) disable iff (!rst_n)
    start && uflow_hit |=> cc[3]); // R9
  AST_SIGN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(cc[1:0]) <= 1); // R9
endmodule

bind hexfp_normalizer hexfp_normalizer_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DIG_W(DIG_W), .CC_W(CC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .long_fmt(long_fmt),
  .unnorm_mode(unnorm_mode), .uflow_zero(uflow_zero), .exp_in(exp_in),
  .frac_in(frac_in), .done(done), .exp_out(exp_out), .frac_out(frac_out),
  .sig_fault(sig_fault), .uflow_fault(uflow_fault), .cc(cc),
  .shift_amt(shift_amt), .uflow_hit(uflow_hit)
);

// File: tb/hexfp_normalizer_bench.sv
module hexfp_normalizer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        long_fmt = 1'b0;
  logic        unnorm_mode = 1'b0;
  logic        sig_chk_en = 1'b0;
  logic        uflow_zero = 1'b0;
  logic        zero_chk_en = 1'b0;
  logic        sign_in = 1'b0;
  logic [6:0]  exp_in = '0;
  logic [55:0] frac_in = '0;
  logic        done, sign_out, sig_fault, uflow_fault;
  logic [6:0]  exp_out;
  logic [55:0] frac_out;
  logic [3:0]  cc;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  hexfp_normalizer u_hexfp_normalizer (
    .clk(clk), .rst_n(rst_n), .start(start), .long_fmt(long_fmt),
    .unnorm_mode(unnorm_mode), .sig_chk_en(sig_chk_en), .uflow_zero(uflow_zero),
    .zero_chk_en(zero_chk_en), .sign_in(sign_in), .exp_in(exp_in), .frac_in(frac_in),
    .done(done), .sign_out(sign_out), .exp_out(exp_out), .frac_out(frac_out),
    .sig_fault(sig_fault), .uflow_fault(uflow_fault), .cc(cc)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // bench model: shift digit by digit in a loop
  task automatic run_case(input string tag, input logic lf, input logic un,
                          input logic sce, input logic uz, input logic zce,
                          input logic s, input logic [6:0] e, input logic [55:0] f);
    logic [55:0] m;
    int          n;
    logic        uf, sg, fz, es;
    logic [6:0]  ee;
    logic [55:0] ef;
    logic [3:0]  ecc;
    m = lf ? f : {f[55:32], 32'h0};
    n = 0;
    if (!un && m != 0) begin
      while (m[55:52] == 4'h0) begin
        m = m << 4;
        n++;
      end
    end
    uf = (n > int'(e));
    sg = sce && (n > 2);
    fz = (m == 0 && zce) || (uf && uz);
    es = fz ? 1'b0 : s;
    ee = fz ? 7'h0 : 7'(int'(e) - n);
    ef = fz ? 56'h0 : m;
    ecc = {uf, sg, es && ef != 0, !es && ef != 0};

    @(negedge clk);
    start = 1'b1; long_fmt = lf; unnorm_mode = un; sig_chk_en = sce;
    uflow_zero = uz; zero_chk_en = zce; sign_in = s; exp_in = e; frac_in = f;
    @(negedge clk);
    start = 1'b0;
    check(tag, "done", 64'(done), 64'd1);
    check(tag, "sign", 64'(sign_out), 64'(es));
    check(tag, "exp", 64'(exp_out), 64'(ee));
    check(tag, "frac", 64'(frac_out), 64'(ef));
    check(tag, "sig_fault", 64'(sig_fault), 64'(sg));
    check(tag, "uflow_fault", 64'(uflow_fault), 64'(uf && !uz));
    check(tag, "cc", 64'(cc), 64'(ecc));
    // change inputs without a strobe; outputs must hold (R2)
    frac_in = ~f; exp_in = ~e; sign_in = ~s;
    @(negedge clk);
    check("R2", "done_drop", 64'(done), 64'd0);
    check("R2", "hold_frac", 64'(frac_out), 64'(ef));
    check("R2", "hold_exp", 64'(exp_out), 64'(ee));
  endtask

  task automatic t_reset();
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "sign", 64'(sign_out), 64'd0);
    check("R1", "exp", 64'(exp_out), 64'd0);
    check("R1", "frac", 64'(frac_out), 64'd0);
    check("R1", "faults", 64'({sig_fault, uflow_fault}), 64'd0);
    check("R1", "cc", 64'(cc), 64'd0);
  endtask

  task automatic t_short_norm();
    run_case("R3", 0, 0, 1, 0, 1, 1, 7'h40, 56'h123456_DEADBEEF);
    run_case("R3", 0, 0, 1, 0, 1, 0, 7'h41, 56'h000ABC_00000000);
    run_case("R3", 0, 0, 0, 0, 1, 0, 7'h42, 56'h00007F_FFFFFFFF);
  endtask

  task automatic t_long_norm();
    run_case("R3", 1, 0, 1, 0, 1, 0, 7'h44, 56'h00_9876_5432_1000);
    run_case("R3", 1, 0, 1, 0, 1, 1, 7'h30, 56'h00000000_00F0F1);
  endtask

  task automatic t_unnorm();
    run_case("R4", 1, 1, 1, 0, 1, 1, 7'h02, 56'h0000_0012_3456_78);
    run_case("R4", 0, 1, 1, 0, 1, 0, 7'h10, 56'h00000A_12345678);
  endtask

  task automatic t_sig();
    run_case("R5", 1, 0, 1, 0, 1, 0, 7'h50, 56'h00000000000001);
    run_case("R5", 1, 0, 1, 0, 1, 0, 7'h50, 56'h000ABCDEF00000);
    run_case("R5", 1, 0, 0, 0, 1, 0, 7'h50, 56'h0000ABCDEF0000);
    run_case("R5", 0, 0, 1, 1, 1, 1, 7'h01, 56'h000001_00000000);
  endtask

  task automatic t_uflow();
    run_case("R6", 1, 0, 0, 0, 1, 1, 7'h02, 56'h000F0000000000);
    run_case("R6", 0, 0, 1, 0, 1, 0, 7'h00, 56'h0C0000_00000000);
    run_case("R7", 1, 0, 0, 1, 1, 1, 7'h02, 56'h000F0000000000);
    run_case("R7", 1, 0, 1, 1, 1, 0, 7'h03, 56'h000F0000000000);
  endtask

  task automatic t_zero();
    run_case("R8", 1, 0, 1, 0, 1, 1, 7'h45, 56'h0);
    run_case("R8", 1, 0, 1, 0, 0, 1, 7'h45, 56'h0);
    run_case("R8", 0, 0, 1, 0, 0, 0, 7'h33, 56'h000000_FFFFFFFF);
  endtask

  task automatic t_cc();
    run_case("R9", 1, 0, 0, 0, 1, 1, 7'h40, 56'h80000000000000);
    run_case("R9", 1, 0, 0, 0, 1, 0, 7'h40, 56'h10000000000000);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_norm();
    t_long_norm();
    t_unnorm();
    t_sig();
    t_uflow();
    t_zero();
    t_cc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule